// File: doc/BRIEF.md
# Timing Reference Failover Selector

This block picks the timing reference that drives the system clock. There are three candidates: a primary external reference, a secondary external reference, and an internal free-running oscillator. Each external reference is sampled in the local clock domain and judged against a frequency tolerance. A fixed window of local clock cycles counts the reference's rising edges, and the count is compared against programmable lower and upper limits. Programmable run lengths of consecutive windows qualify a reference as healthy or declare it failed, so that a marginal reference does not make the selection chatter.

In automatic operation the selection follows a fixed priority. The primary is used when healthy, then the secondary, and the internal oscillator when both externals are down. The selection returns to the primary as soon as the primary is healthy again. Software can also command a specific source. The command holds while that source stays healthy. A command naming a failed reference is refused and recorded in a sticky error flag. The outputs are a source code, a one-hot clock-mux control, per-reference health flags and two alarm levels.

Top module: `tref_select`

## Requirements
- R1: While reset is held and in the first cycle after it, the selected source is internal (code 0), the mux control is 3'b001, the major alarm is set, and both health flags, the minor alarm and the command error are low.
- R2: The source codes are internal = 0, primary = 1 and secondary = 2, and code 3 never appears. The mux control is one-hot, and its set bit index equals the source code.
- R3: Every WIN_LEN local clock cycles, a window closes and the rising edges of each reference seen during it are counted. The window is in range when lim_lo <= count <= lim_hi, with both limits inclusive.
- R4: A healthy reference is declared failed after fail_n consecutive out-of-range windows (a value of 0 acts as 1).
- R5: A failed reference is declared healthy after good_m consecutive in-range windows (0 acts as 1). Both references start out failed after reset, so internal timing is used until the primary qualifies.
- R6: In automatic mode the selection is primary if it is healthy, else secondary if it is healthy, else internal. The selection register updates on the clock edge after a health flag changes.
- R7: In automatic mode the selection reverts to the primary from either secondary or internal as soon as the primary is healthy.
- R8: When usr_req is high at a clock edge, usr_sel = 0, 1 or 2 selects and holds that source at that same edge, and usr_sel = 3 returns to automatic mode. A held secondary or internal selection does not revert to a healthy primary.
- R9: If a held external source fails, the hold is dropped and automatic selection resumes.
- R10: A command naming a failed external reference leaves the selection unchanged and sets cmd_err, which stays set until reset.
- R11: The minor alarm is high exactly while the secondary is selected and the major alarm exactly while internal is selected, never both.
- R12: The health flags change only on the clock edge that closes a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local counter clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pri | input | 1 | Primary reference, synchronous to clk |
| ref_sec | input | 1 | Secondary reference, synchronous to clk |
| lim_lo | input | CNT_W | Minimum in-range edge count per window |
| lim_hi | input | CNT_W | Maximum in-range edge count per window |
| fail_n | input | RUN_W | Consecutive bad windows to declare failure |
| good_m | input | RUN_W | Consecutive good windows to declare health |
| usr_req | input | 1 | Command strobe |
| usr_sel | input | 2 | Command: 0 internal, 1 primary, 2 secondary, 3 automatic |
| sel_src | output | 2 | Selected source code |
| clk_mux | output | 3 | One-hot clock mux control |
| pri_ok | output | 1 | Primary reference healthy |
| sec_ok | output | 1 | Secondary reference healthy |
| alarm_minor | output | 1 | Running on secondary |
| alarm_major | output | 1 | Running on internal oscillator |
| cmd_err | output | 1 | Sticky: a command was refused |

## Verification
The assertions check several properties on every cycle. The source code must stay legal and the mux control one-hot. The two alarms must never be set together. A selected reference that has lost health must be left on the next edge, the refused-command flag must stay sticky, and the health flags may move only after a window closes. The priority order, the revertive return, the hold semantics of manual commands and the inclusive tolerance limits depend on sequences of reference behaviour, so only the bench's scenarios can show them. Those scenarios include a sweep over the fail and qualify run lengths.

// File: rtl/tref_pkg.sv
package tref_pkg;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_PRI = 2'd1,
        SRC_SEC = 2'd2
    } src_e;

    localparam logic [1:0] CMD_AUTO = 2'd3;
    localparam int NUM_REF = 2;

    typedef struct packed {
        logic manual;
        src_e target;
        logic err;
        src_e sel;
    } sel_state_t;

    function automatic logic [2:0] src_onehot(input src_e s);
        logic [2:0] v;
        v = 3'b000;
        v[s] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/tref_window.sv
module tref_window #(
    parameter int WIN_LEN = 64,
    localparam int TW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1
) (
    input  logic clk,
    input  logic rst,
    output logic win_end
);
    logic [TW-1:0] tcnt;

    assign win_end = (tcnt == TW'(WIN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst)          tcnt <= '0;
        else if (win_end) tcnt <= '0;
        else              tcnt <= tcnt + 1'b1;
    end
endmodule

// File: rtl/tref_monitor.sv
module tref_monitor #(
    parameter int CNT_W = 7,
    parameter int RUN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             win_end,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    input  logic [RUN_W-1:0] fail_n,
    input  logic [RUN_W-1:0] good_m,
    output logic             ok
);
    logic             prev;
    logic             rise;
    logic [CNT_W-1:0] edges;
    logic [CNT_W:0]   total;
    logic             in_rng;
    logic [RUN_W-1:0] run;
    logic [RUN_W:0]   run_nx;
    logic [RUN_W-1:0] thresh;

    assign rise   = ref_in & ~prev;
    assign total  = {1'b0, edges} + {{CNT_W{1'b0}}, rise};
    assign in_rng = (total >= {1'b0, lim_lo}) && (total <= {1'b0, lim_hi});
    assign run_nx = {1'b0, run} + 1'b1;
    assign thresh = ok ? fail_n : good_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= 1'b0;
            edges <= '0;
            run   <= '0;
            ok    <= 1'b0;
        end else begin
            prev <= ref_in;
            if (win_end) begin
                edges <= '0;
                if (ok == in_rng) begin
                    run <= '0;
                end else if (run_nx >= {1'b0, thresh}) begin
                    ok  <= in_rng;
                    run <= '0;
                end else begin
                    run <= run_nx[RUN_W-1:0];
                end
            end else if (rise && (edges != {CNT_W{1'b1}})) begin
                edges <= edges + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tref_policy.sv
module tref_policy
    import tref_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pri_ok,
    input  logic       sec_ok,
    input  logic       usr_req,
    input  logic [1:0] usr_sel,
    output src_e       sel,
    output logic       err
);
    sel_state_t st, st_n;
    src_e       auto_pick;

    function automatic logic healthy(input src_e s, input logic p, input logic q);
        case (s)
            SRC_PRI: return p;
            SRC_SEC: return q;
            default: return 1'b1;
        endcase
    endfunction

    always_comb begin
        if (pri_ok)      auto_pick = SRC_PRI;
        else if (sec_ok) auto_pick = SRC_SEC;
        else             auto_pick = SRC_INT;
    end

    always_comb begin
        st_n = st;
        if (usr_req) begin
            if (usr_sel == CMD_AUTO) begin
                st_n.manual = 1'b0;
            end else if (healthy(src_e'(usr_sel), pri_ok, sec_ok)) begin
                st_n.manual = 1'b1;
                st_n.target = src_e'(usr_sel);
            end else begin
                st_n.err = 1'b1;
            end
        end
        if (st_n.manual && !healthy(st_n.target, pri_ok, sec_ok))
            st_n.manual = 1'b0;
        st_n.sel = st_n.manual ? st_n.target : auto_pick;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '{manual: 1'b0, target: SRC_INT, err: 1'b0, sel: SRC_INT};
        else     st <= st_n;
    end

    assign sel = st.sel;
    assign err = st.err;
endmodule

// File: rtl/tref_select.sv
module tref_select
    import tref_pkg::*;
#(
    parameter int WIN_LEN = 64,
    parameter int RUN_W   = 4,
    localparam int CNT_W  = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_pri,
    input  logic             ref_sec,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    input  logic [RUN_W-1:0] fail_n,
    input  logic [RUN_W-1:0] good_m,
    input  logic             usr_req,
    input  logic [1:0]       usr_sel,
    output logic [1:0]       sel_src,
    output logic [2:0]       clk_mux,
    output logic             pri_ok,
    output logic             sec_ok,
    output logic             alarm_minor,
    output logic             alarm_major,
    output logic             cmd_err
);
    logic               win_end;
    logic [NUM_REF-1:0] refs;
    logic [NUM_REF-1:0] oks;
    src_e               sel;

    assign refs = {ref_sec, ref_pri};

    tref_window #(.WIN_LEN(WIN_LEN)) u_win (
        .clk(clk), .rst(rst), .win_end(win_end)
    );

    for (genvar g = 0; g < NUM_REF; g++) begin : g_mon
        tref_monitor #(.CNT_W(CNT_W), .RUN_W(RUN_W)) u_mon (
            .clk(clk), .rst(rst), .ref_in(refs[g]), .win_end(win_end),
            .lim_lo(lim_lo), .lim_hi(lim_hi), .fail_n(fail_n),
            .good_m(good_m), .ok(oks[g])
        );
    end

    tref_policy u_pol (
        .clk(clk), .rst(rst), .pri_ok(oks[0]), .sec_ok(oks[1]),
        .usr_req(usr_req), .usr_sel(usr_sel), .sel(sel), .err(cmd_err)
    );

    assign pri_ok      = oks[0];
    assign sec_ok      = oks[1];
    assign sel_src     = sel;
    assign clk_mux     = src_onehot(sel);
    assign alarm_minor = (sel == SRC_SEC);
    assign alarm_major = (sel == SRC_INT);
endmodule

// File: rtl/tref_select_chk.sv
module tref_select_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] sel_src,
    input logic [2:0] clk_mux,
    input logic       pri_ok,
    input logic       sec_ok,
    input logic       alarm_minor,
    input logic       alarm_major,
    input logic       cmd_err,
    input logic       win_end
);
    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        sel_src != 2'd3);

    // R2
    mux_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(clk_mux) == 1);

    // R11
    alarm_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(alarm_minor && alarm_major));

    // R6
    leave_pri_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_src == 2'd1 && !pri_ok) |=> (sel_src != 2'd1));

    // R6
    leave_sec_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_src == 2'd2 && !sec_ok) |=> (sel_src != 2'd2));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> cmd_err);

    // R12
    pri_win_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pri_ok) |-> $past(win_end));

    // R12
    sec_win_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sec_ok) |-> $past(win_end));
endmodule

bind tref_select tref_select_chk u_chk (
    .clk(clk), .rst(rst), .sel_src(sel_src), .clk_mux(clk_mux),
    .pri_ok(pri_ok), .sec_ok(sec_ok), .alarm_minor(alarm_minor),
    .alarm_major(alarm_major), .cmd_err(cmd_err), .win_end(win_end)
);

// File: tb/sim_tref_select.sv
module sim_tref_select;
    localparam int W = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_pri = 1'b0, ref_sec = 1'b0;
    logic [4:0] lim_lo = 5'd3, lim_hi = 5'd5;
    logic [3:0] fail_n = 4'd2, good_m = 4'd2;
    logic       usr_req = 1'b0;
    logic [1:0] usr_sel = 2'd3;
    logic [1:0] sel_src;
    logic [2:0] clk_mux;
    logic       pri_ok, sec_ok, alarm_minor, alarm_major, cmd_err;

    int pa = 0, pb = 0;
    int ph = 0;
    int vecs = 0, bad = 0;

    always #4 clk = ~clk;

    tref_select #(.WIN_LEN(W), .RUN_W(4)) u0 (
        .clk(clk), .rst(rst), .ref_pri(ref_pri), .ref_sec(ref_sec),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .fail_n(fail_n), .good_m(good_m),
        .usr_req(usr_req), .usr_sel(usr_sel), .sel_src(sel_src),
        .clk_mux(clk_mux), .pri_ok(pri_ok), .sec_ok(sec_ok),
        .alarm_minor(alarm_minor), .alarm_major(alarm_major), .cmd_err(cmd_err)
    );

    // reference generators: period in clk cycles, 0 means stuck low
    initial begin
        forever begin
            @(negedge clk);
            ph = ph + 1;
            ref_pri = (pa != 0) && ((ph % pa) < (pa / 2));
            ref_sec = (pb != 0) && ((ph % pb) < (pb / 2));
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic cmd(input logic [1:0] c);
        @(negedge clk);
        usr_req = 1'b1;
        usr_sel = c;
        @(negedge clk);
        usr_req = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic expect_sel(input string tag, input int code);
        chk(tag, sel_src, code);
        chk(tag, clk_mux, 1 << code);
        chk(tag, alarm_minor, code == 2);
        chk(tag, alarm_major, code == 0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        #1;
        expect_sel("R1 in reset", 0);
        chk("R1 pri_ok", pri_ok, 0);
        chk("R1 sec_ok", sec_ok, 0);
        chk("R1 cmd_err", cmd_err, 0);
        rst = 1'b0;
        step(1);
        expect_sel("R1 after reset", 0);

        // R4/R5 sweep over run lengths
        for (int n = 1; n <= 3; n++) begin
            for (int m = 1; m <= 3; m++) begin
                fail_n = 4'(n);
                good_m = 4'(m);
                pa = 4; pb = 4;
                do_reset();
                if (m > 1) begin
                    step((m - 1) * W + W / 2);
                    chk("R5 not yet qualified", pri_ok, 0);
                    expect_sel("R5 internal until qualified", 0);
                    step(2 * W);
                end else begin
                    step(2 * W + 3);
                end
                chk("R5 qualified", pri_ok, 1);
                expect_sel("R5 primary selected", 1);
                pa = 0;
                if (n > 1) begin
                    step((n - 1) * W - 1);
                    chk("R4 R12 still healthy", pri_ok, 1);
                    step(2 * W + 4);
                end else begin
                    step(2 * W + 3);
                end
                chk("R4 declared failed", pri_ok, 0);
                expect_sel("R4 R6 fell to secondary", 2);
            end
        end

        // main scenarios with N=2, M=2
        fail_n = 4'd2; good_m = 4'd2;
        pa = 4; pb = 4;
        do_reset();
        step(3 * W + 3);
        expect_sel("R6 primary first", 1);
        chk("R6 sec_ok", sec_ok, 1);

        cmd(2'd2);
        expect_sel("R8 manual secondary", 2);
        step(3 * W);
        expect_sel("R8 hold without revert", 2);
        cmd(2'd3);
        expect_sel("R8 back to auto", 1);
        cmd(2'd0);
        expect_sel("R8 R11 manual internal", 0);
        cmd(2'd3);
        expect_sel("R8 auto again", 1);

        pb = 0;
        step(3 * W + 3);
        chk("R4 sec failed", sec_ok, 0);
        expect_sel("R6 primary kept", 1);
        cmd(2'd2);
        expect_sel("R10 refused command", 1);
        chk("R10 cmd_err set", cmd_err, 1);
        pb = 4;
        step(3 * W + 3);
        chk("R5 sec requalified", sec_ok, 1);
        chk("R10 cmd_err sticky", cmd_err, 1);

        cmd(2'd2);
        expect_sel("R8 manual secondary 2", 2);
        pb = 0;
        step(3 * W + 3);
        expect_sel("R9 hold dropped", 1);

        pb = 4;
        step(3 * W + 3);
        pa = 0;
        step(3 * W + 3);
        expect_sel("R6 R11 on secondary", 2);
        pb = 0;
        step(3 * W + 3);
        expect_sel("R6 R11 on internal", 0);
        pa = 2;
        step(4 * W);
        chk("R3 above upper limit", pri_ok, 0);
        expect_sel("R3 still internal", 0);
        pa = 4;
        step(3 * W + 3);
        expect_sel("R7 revert from internal", 1);

        pb = 4;
        step(3 * W + 3);
        pa = 8;
        step(3 * W + 3);
        chk("R3 below lower limit", pri_ok, 0);
        expect_sel("R3 moved to secondary", 2);
        pa = 4;
        step(3 * W + 3);
        expect_sel("R7 revert from secondary", 1);

        lim_lo = 5'd4; lim_hi = 5'd4;
        step(4 * W);
        chk("R3 inclusive limits", pri_ok, 1);
        expect_sel("R3 primary kept", 1);

        do_reset();
        step(1);
        chk("R1 reset clears cmd_err", cmd_err, 0);
        expect_sel("R1 reset internal", 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule